// File: doc/BRIEF.md
# Configurable Scratchpad Memory Tile

A storage tile for a mesh of reconfigurable compute cells. The neighbouring cells present only an element index. The tile adds a base offset to that index and scales the sum by a selectable element width of 4, 8, 16 or 32 bits, so several logical arrays with different element sizes can live in separate regions of one memory. Elements pack densely into 32-bit words. A read returns the addressed element one clock later, extended to 32 bits either with its sign or with zeros.

All mesh-side controls are taken anew on every clock: base, index, width, sign choice and write data. Writes happen only when the central controller raises the write enable. Without it, the tile acts as a read-only table. A sub-word write merges the new element into the stored word under a lane mask, so the other lanes in that word keep their values.

A separate host port fills and drains the memory in bursts while host mode is set. A start pulse loads a word pointer, and every beat reads or writes one full word and then advances the pointer. In host mode the mesh cannot write.

Top module: `spm_tile`

## Requirements
- R1: While reset is low and on the first clock after reset is released, `rdata` and `host_rdata` are zero.
- R2: The element address is `(base + idx)` modulo 2^EW. Width codes are `mode` 0 = 4 bits, 1 = 8 bits, 2 = 16 bits and 3 = 32 bits. The word address is the element address shifted right by 3, 2, 1 or 0 for codes 0 to 3, taken modulo DEPTH.
- R3: Inside a word, element k of the selected width occupies bits starting at k·width, where k is the element address modulo 32/width. The lowest element is in the lowest bits.
- R4: A mesh write changes only the bits of the addressed element. All other bits of that word are unchanged.
- R5: `rdata` shows the element addressed in a cycle on the next clock. If the same cycle writes that element, `rdata` shows the value held before the write.
- R6: With `sign_ext` = 1 the read element is sign-extended to 32 bits. With `sign_ext` = 0 it is zero-extended.
- R7: The memory is written from the mesh port only when `wr_en` = 1 and `host_mode` = 0. With `host_mode` = 1, `wr_en` has no effect.
- R8: In host mode, a `host_start` pulse makes `host_addr` the access address for that cycle. Otherwise the access address is the pointer. Each `host_beat` accesses one full word and leaves the pointer at the access address plus one, modulo DEPTH.
- R9: A host read beat (`host_we` = 0) places that word on `host_rdata` on the next clock. In all other cycles `host_rdata` holds its value.
- R10: Base, index, width, sign choice and write data may change on every clock, with no idle cycle between accesses of different widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base | input | EW | Region base, in elements |
| idx | input | EW | Element index from the mesh |
| mode | input | 2 | Element width code |
| sign_ext | input | 1 | 1: sign-extend reads; 0: zero-extend |
| wdata | input | 32 | Write element in the low bits |
| wr_en | input | 1 | Write enable from the controller |
| rdata | output | 32 | Extended read element, one clock late |
| host_mode | input | 1 | Host burst mode |
| host_start | input | 1 | Load the burst pointer from host_addr |
| host_beat | input | 1 | Perform one host word access |
| host_we | input | 1 | 1: beat writes; 0: beat reads |
| host_addr | input | AW | Burst start word |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word |

## Verification
The hardest case to reach from the ports is a mesh write that is attempted in host mode. A leak would change a word silently, and no port shows the change until that word is read again from the mesh. The stimulus therefore fills the whole memory over the host port while `wr_en` is held high with other data. It then sweeps every word back through the mesh port at full width, so any leaked write shows up as a mismatch. Random accesses then aim nearby indices at a few words with mixed widths, so that sub-word merges and same-cycle read-during-write collisions occur often.

// File: rtl/spm_tile.sv
module spm_tile #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int EW = AW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] base,
  input  logic [EW-1:0] idx,
  input  logic [1:0]    mode,
  input  logic          sign_ext,
  input  logic [31:0]   wdata,
  input  logic          wr_en,
  output logic [31:0]   rdata,
  input  logic          host_mode,
  input  logic          host_start,
  input  logic          host_beat,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata
);

  logic [31:0]   mem [DEPTH];
  logic [EW-1:0] elem;
  logic [AW-1:0] waddr, hsel, hptr;
  logic [2:0]    lane, rd_lane;
  logic [31:0]   fmask, wmask, wshift, rd_word, rd_shift;
  logic [1:0]    rd_mode;
  logic          rd_sign;

  assign elem = base + idx;

  always_comb begin
    case (mode)
      2'd0:    begin waddr = elem[AW+2:3]; lane = elem[2:0];          fmask = 32'h0000_000F; end
      2'd1:    begin waddr = elem[AW+1:2]; lane = {elem[1:0], 1'b0};  fmask = 32'h0000_00FF; end
      2'd2:    begin waddr = elem[AW:1];   lane = {elem[0], 2'b00};   fmask = 32'h0000_FFFF; end
      default: begin waddr = elem[AW-1:0]; lane = 3'd0;               fmask = 32'hFFFF_FFFF; end
    endcase
  end

  assign wmask  = fmask << {lane, 2'b00};
  assign wshift = wdata << {lane, 2'b00};
  assign hsel   = host_start ? host_addr : hptr;

  always_ff @(posedge clk) begin
    if (host_mode && host_beat && host_we)
      mem[hsel] <= host_wdata;
    else if (!host_mode && wr_en)
      mem[waddr] <= (mem[waddr] & ~wmask) | (wshift & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word    <= '0;
      rd_lane    <= '0;
      rd_mode    <= '0;
      rd_sign    <= 1'b0;
      hptr       <= '0;
      host_rdata <= '0;
    end else begin
      rd_word <= mem[waddr];
      rd_lane <= lane;
      rd_mode <= mode;
      rd_sign <= sign_ext;
      if (host_mode) begin
        if (host_start || host_beat) hptr <= hsel + AW'(host_beat);
        if (host_beat && !host_we)   host_rdata <= mem[hsel];
      end
    end
  end

  assign rd_shift = rd_word >> {rd_lane, 2'b00};

  always_comb begin
    case (rd_mode)
      2'd0:    rdata = {{28{rd_sign & rd_shift[3]}},  rd_shift[3:0]};
      2'd1:    rdata = {{24{rd_sign & rd_shift[7]}},  rd_shift[7:0]};
      2'd2:    rdata = {{16{rd_sign & rd_shift[15]}}, rd_shift[15:0]};
      default: rdata = rd_shift;
    endcase
  end

endmodule

// File: rtl/spm_tile_chk.sv
module spm_tile_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          sign_ext,
  input logic          host_mode,
  input logic          host_start,
  input logic          host_beat,
  input logic          host_we,
  input logic [AW-1:0] hptr,
  input logic [31:0]   rdata,
  input logic [31:0]   host_rdata
);

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rdata == 32'd0 && host_rdata == 32'd0));

  p_sign_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sign_ext && mode == 2'd0) |-> (rdata[31:3] == '0 || rdata[31:3] == '1));

  p_zero_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sign_ext && mode == 2'd0) |-> rdata[31:4] == '0);

  p_zero_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sign_ext && mode == 2'd1) |-> rdata[31:8] == '0);

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_mode && host_beat && !host_start) |-> hptr == $past(hptr) + AW'(1));

  p_host_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_mode && host_beat && !host_we) |-> $stable(host_rdata));

endmodule

bind spm_tile spm_tile_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sign_ext(sign_ext),
  .host_mode(host_mode), .host_start(host_start), .host_beat(host_beat),
  .host_we(host_we), .hptr(hptr), .rdata(rdata), .host_rdata(host_rdata)
);

// File: tb/spm_tile_bench.sv
`timescale 1ns/1ps
module spm_tile_bench;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int EW = AW + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [EW-1:0] base = '0, idx = '0;
  logic [1:0] mode = '0;
  logic sign_ext = 1'b0, wr_en = 1'b0;
  logic [31:0] wdata = '0, rdata, host_wdata = '0, host_rdata;
  logic host_mode = 1'b0, host_start = 1'b0, host_beat = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] model [DEPTH];
  logic [AW-1:0] ptr_m = '0;
  logic [31:0] exp_h = '0;

  always #10 clk = ~clk;

  spm_tile #(.DEPTH(DEPTH)) u_spm_tile (.*);

  function automatic logic [AW-1:0] f_word(logic [EW-1:0] e, logic [1:0] m);
    return AW'(e >> (3 - m));
  endfunction

  function automatic int f_bit(logic [EW-1:0] e, logic [1:0] m);
    return int'(e % (8 >> m)) * (4 << m);
  endfunction

  function automatic logic [31:0] f_mask(logic [1:0] m);
    return (m == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << (4 << m)) - 32'd1);
  endfunction

  function automatic logic [31:0] f_ext(logic [31:0] raw, logic [1:0] m, logic s);
    logic [31:0] v = raw & f_mask(m);
    if (m != 2'd3 && s && v[(4 << m) - 1]) v = v | ~f_mask(m);
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mesh_step(logic [EW-1:0] b, logic [EW-1:0] i, logic [1:0] m, logic s,
                           logic [31:0] wd, logic we, string tag);
    logic [EW-1:0] e;
    logic [AW-1:0] w;
    int sh;
    logic [31:0] ex;
    base = b; idx = i; mode = m; sign_ext = s; wdata = wd; wr_en = we;
    host_mode = 1'b0; host_start = 1'b0; host_beat = 1'b0;
    e = b + i; w = f_word(e, m); sh = f_bit(e, m);
    ex = f_ext(model[w] >> sh, m, s);
    if (we) model[w] = (model[w] & ~(f_mask(m) << sh)) | ((wd & f_mask(m)) << sh);
    @(negedge clk);
    check(tag, rdata, ex);
  endtask

  task automatic host_step(logic st, logic [AW-1:0] a, logic bt, logic we,
                           logic [31:0] wd, string tag);
    logic [AW-1:0] sel;
    host_mode = 1'b1; host_start = st; host_addr = a; host_beat = bt;
    host_we = we; host_wdata = wd;
    wr_en = 1'b1; wdata = ~wd; mode = $urandom % 4; idx = $urandom; base = $urandom;
    sel = st ? a : ptr_m;
    if (bt && we) model[sel] = wd;
    if (bt && !we) exp_h = model[sel];
    if (st || bt) ptr_m = sel + AW'(bt);
    @(negedge clk);
    check(tag, host_rdata, exp_h);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 rdata", rdata, 32'd0);
    check("R1 host_rdata", host_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", host_rdata, 32'd0);

    // R7 R8: host fill while mesh write enable is held high
    for (int k = 0; k < DEPTH; k++)
      host_step(k == 0, '0, 1'b1, 1'b1, 32'h9E37_79B1 * (k + 1), "R8 fill");
    // R8 wrap: burst read across the top of memory
    for (int k = 0; k < 6; k++)
      host_step(k == 0, AW'(DEPTH - 3), 1'b1, 1'b0, '0, "R8 R9 wrap read");
    for (int k = 0; k < 3; k++)
      host_step(1'b0, '0, 1'b0, 1'b0, '0, "R9 hold");

    // R7: full-width mesh sweep proves no mesh write leaked during host mode
    for (int k = 0; k < DEPTH; k++)
      mesh_step(EW'(k), '0, 2'd3, 1'b0, '0, 1'b0, "R7 sweep");

    // R6: nibble sign handling
    mesh_step(EW'(0), EW'(5), 2'd0, 1'b0, 32'h9, 1'b1, "R5 write");
    mesh_step(EW'(5), EW'(0), 2'd0, 1'b1, '0, 1'b0, "R6 signed nibble");
    check("R6 value", rdata, 32'hFFFF_FFF9);
    mesh_step(EW'(2), EW'(3), 2'd0, 1'b0, '0, 1'b0, "R6 unsigned nibble");
    check("R2 base+idx", rdata, 32'h0000_0009);
    // R5: read during write returns old value
    mesh_step(EW'(1), EW'(4), 2'd0, 1'b0, 32'h3, 1'b1, "R5 old value");
    check("R5 old value direct", rdata, 32'h9);
    // R4 R3: byte write leaves neighbours, check every byte lane
    mesh_step(EW'(8), EW'(1), 2'd1, 1'b0, 32'hA5, 1'b1, "R4 byte write");
    for (int k = 0; k < 4; k++)
      mesh_step(EW'(8), EW'(k), 2'd1, 1'b1, '0, 1'b0, "R3 R4 byte lanes");
    mesh_step(EW'(4), EW'(1), 2'd2, 1'b1, 32'h8001, 1'b1, "R4 half write");
    mesh_step(EW'(5), EW'(0), 2'd2, 1'b1, '0, 1'b0, "R6 signed half");
    check("R6 half value", rdata, 32'hFFFF_8001);
    // R2: index wraps modulo element space
    mesh_step('1, EW'(2), 2'd3, 1'b0, '0, 1'b0, "R2 wrap");

    // R10: random mixed widths every cycle, near-colliding addresses
    for (int k = 0; k < 4000; k++)
      mesh_step(EW'($urandom % 24), EW'($urandom % 24), 2'($urandom), 1'($urandom),
                $urandom, ($urandom % 2) == 0, "R10 R2 R3 R4 R5 random");
    // R8 R9: random host bursts
    for (int k = 0; k < 600; k++)
      host_step(($urandom % 16) == 0, AW'($urandom), ($urandom % 3) != 0,
                1'($urandom), $urandom, "R8 R9 random host");
    for (int k = 0; k < DEPTH; k++)
      mesh_step(EW'(k), '0, 2'd3, 1'b0, '0, 1'b0, "R7 R8 final sweep");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule